// File: doc/BRIEF.md
# Accumulator ALU with Logic Operations

This block is the arithmetic and logic core of a small accumulator machine. It keeps two operand registers, an accumulator A and a second operand B, and updates A with the outcome of one of five operations: addition, subtraction, bitwise AND, bitwise OR, and bitwise inversion. A compact opcode decoder turns an instruction opcode into one-hot operation strobes. Each operation has its own strobe, so the datapath treats the three logic operations the same way as add and subtract.

The opcode encodings of the three logic operations use patterns that the instruction set left spare. Inversion is unary: it reads only A, and B has no effect on it. Every result goes back into A when the execute enable is high on a rising clock edge. A and B can also be loaded directly from input data ports, and a combinational result port shows the value A would take.

Top module: `accum_alu`

## Requirements
- R1: A synchronous active-high `rst` clears both `a_q` and `b_q` to zero on the next rising edge.
- R2: `a_load` writes `a_din` into A and `b_load` writes `b_din` into B on a rising edge. When `a_load` and `exec` are both high, the load wins over the operation result.
- R3: A keeps its value on any edge where `a_load` is low and either `exec` is low or the opcode is unassigned (any value other than 0x2, 0x3, 0xD, 0xE, 0xF).
- R4: With opcode 0x2 (add) and `exec` high, A becomes (A + B) modulo 2^WIDTH.
- R5: With opcode 0x3 (subtract) and `exec` high, A becomes A plus the two's complement of B, modulo 2^WIDTH, and the carry out is discarded.
- R6: With opcode 0xD (AND) and `exec` high, A becomes A & B.
- R7: With opcode 0xE (OR) and `exec` high, A becomes A | B.
- R8: With opcode 0xF (NOT) and `exec` high, A becomes ~A. B has no effect on the result, and B itself is left unchanged.
- R9: `op_sel` is one-hot or zero. Bit 0 is add, bit 1 subtract, bit 2 AND, bit 3 OR, bit 4 NOT. An unassigned opcode gives all zeros.
- R10: `result` shows, combinationally, the value the current opcode would produce from the current A and B. For an unassigned opcode it equals A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_load | input | 1 | Load accumulator from `a_din` |
| a_din | input | WIDTH | Direct load data for A |
| b_load | input | 1 | Load operand B from `b_din` |
| b_din | input | WIDTH | Direct load data for B |
| opcode | input | OPW | Instruction opcode |
| exec | input | 1 | Write the operation result into A |
| op_sel | output | 5 | One-hot operation strobes from the decoder |
| result | output | WIDTH | Combinational operation result |
| a_q | output | WIDTH | Accumulator A |
| b_q | output | WIDTH | Operand register B |

## Verification
The bench builds the block with WIDTH = 8, OPW = 4 and RIPPLE = 1. The ripple option selects the bit-level generated carry chain, so the carry and borrow paths are covered: 0xF0 + 0x20 wraps to 0x10, and 0x10 - 0x20 borrows to 0xF0. The default opcode values are kept, so the spare encodings 0xD to 0xF and an unassigned code such as 0x5 can be driven directly. This shows the decoder mapping, the all-zero strobe case and A holding its value.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;
   localparam int NSEL    = 5;
   localparam int SEL_ADD = 0;
   localparam int SEL_SUB = 1;
   localparam int SEL_AND = 2;
   localparam int SEL_OR  = 3;
   localparam int SEL_NOT = 4;
   typedef logic [NSEL-1:0] sel_t;
endpackage

// File: rtl/accum_alu_dec.sv
module accum_alu_dec
   import accum_alu_pkg::*;
#(
   parameter int OPW    = 4,
   parameter int OP_ADD = 2,
   parameter int OP_SUB = 3,
   parameter int OP_AND = 13,
   parameter int OP_OR  = 14,
   parameter int OP_NOT = 15
) (
   input  logic [OPW-1:0] opcode,
   output sel_t           sel
);
   localparam int OPMAX = (1 << OPW) - 1;

   if (OP_ADD > OPMAX || OP_SUB > OPMAX || OP_AND > OPMAX ||
       OP_OR > OPMAX || OP_NOT > OPMAX) begin : g_range_bad
      $error("accum_alu_dec: opcode value exceeds OPW bits");
   end
   if (OP_ADD == OP_SUB || OP_ADD == OP_AND || OP_ADD == OP_OR || OP_ADD == OP_NOT ||
       OP_SUB == OP_AND || OP_SUB == OP_OR || OP_SUB == OP_NOT ||
       OP_AND == OP_OR || OP_AND == OP_NOT || OP_OR == OP_NOT) begin : g_dup_bad
      $error("accum_alu_dec: opcode values must be distinct");
   end

   always_comb begin
      sel          = '0;
      sel[SEL_ADD] = (opcode == OPW'(OP_ADD));
      sel[SEL_SUB] = (opcode == OPW'(OP_SUB));
      sel[SEL_AND] = (opcode == OPW'(OP_AND));
      sel[SEL_OR]  = (opcode == OPW'(OP_OR));
      sel[SEL_NOT] = (opcode == OPW'(OP_NOT));
   end
endmodule

// File: rtl/accum_alu_dp.sv
module accum_alu_dp
   import accum_alu_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  sel_t             sel,
   output logic [WIDTH-1:0] y
);
   logic             sub;
   logic [WIDTH-1:0] bx;
   logic [WIDTH-1:0] sum;

   assign sub = sel[SEL_SUB];
   assign bx  = sub ? ~b : b;

   if (RIPPLE) begin : g_ripple
      logic [WIDTH-1:0] cy;
      assign cy[0] = sub;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i] = a[i] ^ bx[i] ^ cy[i];
         if (i < WIDTH - 1) begin : g_carry
            assign cy[i+1] = (a[i] & bx[i]) | (cy[i] & (a[i] ^ bx[i]));
         end
      end
   end else begin : g_behav
      assign sum = a + bx + WIDTH'(sub);
   end

   always_comb begin
      if (sel[SEL_ADD] || sel[SEL_SUB]) y = sum;
      else if (sel[SEL_AND])            y = a & b;
      else if (sel[SEL_OR])             y = a | b;
      else if (sel[SEL_NOT])            y = ~a;
      else                              y = a;
   end
endmodule

// File: rtl/accum_alu.sv
module accum_alu
   import accum_alu_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int OPW    = 4,
   parameter bit RIPPLE = 1'b0,
   parameter int OP_ADD = 2,
   parameter int OP_SUB = 3,
   parameter int OP_AND = 13,
   parameter int OP_OR  = 14,
   parameter int OP_NOT = 15
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             a_load,
   input  logic [WIDTH-1:0] a_din,
   input  logic             b_load,
   input  logic [WIDTH-1:0] b_din,
   input  logic [OPW-1:0]   opcode,
   input  logic             exec,
   output logic [NSEL-1:0]  op_sel,
   output logic [WIDTH-1:0] result,
   output logic [WIDTH-1:0] a_q,
   output logic [WIDTH-1:0] b_q
);
   if (WIDTH < 2) begin : g_width_bad
      $error("accum_alu: WIDTH must be at least 2");
   end
   if (OPW < 3) begin : g_opw_bad
      $error("accum_alu: OPW must be at least 3");
   end

   sel_t sel;

   accum_alu_dec #(
      .OPW(OPW), .OP_ADD(OP_ADD), .OP_SUB(OP_SUB),
      .OP_AND(OP_AND), .OP_OR(OP_OR), .OP_NOT(OP_NOT)
   ) u_dec (
      .opcode(opcode),
      .sel   (sel)
   );

   accum_alu_dp #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_dp (
      .a  (a_q),
      .b  (b_q),
      .sel(sel),
      .y  (result)
   );

   assign op_sel = sel;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         if (a_load)                a_q <= a_din;
         else if (exec && |sel)     a_q <= result;
         if (b_load)                b_q <= b_din;
      end
   end
endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk
   import accum_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             a_load,
   input logic             b_load,
   input logic             exec,
   input sel_t             sel,
   input logic [WIDTH-1:0] a_q,
   input logic [WIDTH-1:0] b_q
);
   logic run;
   assign run = exec && !a_load;

   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (a_q == '0 && b_q == '0));

   a_r9_onehot_sel: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel));

   a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
      (!a_load && !(exec && |sel)) |=> $stable(a_q));

   a_r4_add: assert property (@(posedge clk) disable iff (rst)
      (run && sel[SEL_ADD]) |=> a_q == WIDTH'($past(a_q) + $past(b_q)));

   a_r5_sub: assert property (@(posedge clk) disable iff (rst)
      (run && sel[SEL_SUB]) |=> a_q == WIDTH'($past(a_q) - $past(b_q)));

   a_r6_and: assert property (@(posedge clk) disable iff (rst)
      (run && sel[SEL_AND]) |=> a_q == ($past(a_q) & $past(b_q)));

   a_r7_or: assert property (@(posedge clk) disable iff (rst)
      (run && sel[SEL_OR]) |=> a_q == ($past(a_q) | $past(b_q)));

   a_r8_not: assert property (@(posedge clk) disable iff (rst)
      (run && sel[SEL_NOT] && !b_load) |=> (a_q == ~$past(a_q) && $stable(b_q)));
endmodule

bind accum_alu accum_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst(rst), .a_load(a_load), .b_load(b_load), .exec(exec),
   .sel(sel), .a_q(a_q), .b_q(b_q)
);

// File: tb/accum_alu_test.sv
module accum_alu_test;
   localparam int W = 8;
   localparam int OW = 4;

   typedef enum int {K_A, K_B, K_SEL, K_RES} kind_t;
   typedef struct {
      kind_t       kind;
      logic [15:0] exp;
      string       tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          a_load = 1'b0, b_load = 1'b0, exec = 1'b0;
   logic [W-1:0]  a_din = '0, b_din = '0;
   logic [OW-1:0] opcode = '0;
   logic [4:0]    op_sel;
   logic [W-1:0]  result, a_q, b_q;

   item_t q[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   accum_alu #(.WIDTH(W), .OPW(OW), .RIPPLE(1'b1)) uut (
      .clk(clk), .rst(rst), .a_load(a_load), .a_din(a_din),
      .b_load(b_load), .b_din(b_din), .opcode(opcode), .exec(exec),
      .op_sel(op_sel), .result(result), .a_q(a_q), .b_q(b_q)
   );

   task automatic expect_v(kind_t k, logic [15:0] v, string t);
      item_t it;
      it.kind = k; it.exp = v; it.tag = t;
      q.push_back(it);
   endtask

   task automatic load_ab(logic [W-1:0] av, logic [W-1:0] bv);
      @(negedge clk);
      a_din = av; b_din = bv; a_load = 1'b1; b_load = 1'b1;
      @(negedge clk);
      a_load = 1'b0; b_load = 1'b0;
   endtask

   task automatic run_op(logic [OW-1:0] op, logic [W-1:0] exp_a, string t);
      @(negedge clk);
      opcode = op; exec = 1'b1;
      @(negedge clk);
      exec = 1'b0;
      expect_v(K_A, 16'(exp_a), t);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // monitor: compare after the driver has queued its expectations
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.kind)
               K_A:     act = 16'(a_q);
               K_B:     act = 16'(b_q);
               K_SEL:   act = 16'(op_sel);
               default: act = 16'(result);
            endcase
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst = 1'b0;
      expect_v(K_A, 16'h00, "R1 reset A");
      expect_v(K_B, 16'h00, "R1 reset B");

      // R9 decoder strobes and R10 combinational result
      load_ab(8'hCA, 8'h0F);
      expect_v(K_A, 16'hCA, "R2 load A");
      expect_v(K_B, 16'h0F, "R2 load B");
      opcode = 4'h2; expect_v(K_SEL, 16'h01, "R9 sel add");
      expect_v(K_RES, 16'hD9, "R10 result add");
      @(negedge clk); opcode = 4'h3; expect_v(K_SEL, 16'h02, "R9 sel sub");
      expect_v(K_RES, 16'hBB, "R10 result sub");
      @(negedge clk); opcode = 4'hD; expect_v(K_SEL, 16'h04, "R9 sel and");
      @(negedge clk); opcode = 4'hE; expect_v(K_SEL, 16'h08, "R9 sel or");
      @(negedge clk); opcode = 4'hF; expect_v(K_SEL, 16'h10, "R9 sel not");
      expect_v(K_RES, 16'h35, "R10 result not");
      @(negedge clk); opcode = 4'h5; expect_v(K_SEL, 16'h00, "R9 sel unassigned");
      expect_v(K_RES, 16'hCA, "R10 result unassigned");

      // R6 and
      run_op(4'hD, 8'h0A, "R6 and");
      // R7 or
      load_ab(8'hA0, 8'h05);
      run_op(4'hE, 8'hA5, "R7 or");
      // R4 add and wrap
      load_ab(8'h12, 8'h34);
      run_op(4'h2, 8'h46, "R4 add");
      load_ab(8'hF0, 8'h20);
      run_op(4'h2, 8'h10, "R4 add wrap");
      // R5 sub and borrow
      load_ab(8'h50, 8'h20);
      run_op(4'h3, 8'h30, "R5 sub");
      load_ab(8'h10, 8'h20);
      run_op(4'h3, 8'hF0, "R5 sub borrow");
      // R8 not ignores B
      load_ab(8'h3C, 8'hFF);
      run_op(4'hF, 8'hC3, "R8 not");
      expect_v(K_B, 16'hFF, "R8 B unchanged");
      load_ab(8'h3C, 8'h00);
      run_op(4'hF, 8'hC3, "R8 not other B");
      // R3 hold on unassigned opcode and on exec low
      run_op(4'h5, 8'hC3, "R3 hold unassigned");
      @(negedge clk); opcode = 4'h2; exec = 1'b0;
      @(negedge clk);
      expect_v(K_A, 16'hC3, "R3 hold exec low");
      // R2 load beats exec
      @(negedge clk);
      a_din = 8'h77; a_load = 1'b1; opcode = 4'hF; exec = 1'b1;
      @(negedge clk);
      a_load = 1'b0; exec = 1'b0;
      expect_v(K_A, 16'h77, "R2 load priority");
      // R1 reset with nonzero state
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      expect_v(K_A, 16'h00, "R1 reset A again");
      expect_v(K_B, 16'h00, "R1 reset B again");

      repeat (3) @(negedge clk);
      done = 1'b1;
      report();
   end
endmodule